// File: doc/BRIEF.md
# Per-Port Receive Statistics Counter Bank

The block keeps a set of receive statistics for each of a small number of input ports. A receive front end reports each finished packet as a one-cycle event. The event carries the port number, the byte length with the CRC included, multicast and broadcast indications, an FCS/alignment error flag and a drop flag. In that cycle the block classifies the packet and increments the counters of that port. It keeps packet and octet totals, a drop pair, address-type counts, a size histogram on the usual Ethernet monitoring boundaries, split runt and oversize counts, and two error counts.

Any counter can be read through a registered read port that takes a port number and a counter index. A global control input selects whether a read also zeroes the counter it returns. The minimum and maximum legal frame lengths are configuration inputs. Every counter saturates at its all-ones value.

Top module: `rxstat_bank`

## Requirements
- R1: After reset every counter reads 0, and `rd_valid` and `rd_data` are 0 until the first read.
- R2: Index 0 counts every event on its port. Index 1 is 64 bits wide and adds the event length, CRC included.
- R3: Index 2 counts events with the drop flag set. Index 3 adds their lengths.
- R4: Index 4 counts multicast events and index 5 counts broadcast events. An event that has both flags set counts only as broadcast.
- R5: Size bins are index 6 (exactly 64), 7 (65–127), 8 (128–255), 9 (256–511), 10 (512–1023), 11 (1024–1518) and 12 (1519 up to the configured maximum). A length below 64 or above the maximum updates no bin.
- R6: A length below the configured minimum increments index 14 when the FCS is good and index 15 when the FCS is bad.
- R7: A length above the configured maximum increments index 16 when the FCS is good and index 17 when the FCS is bad.
- R8: Index 13 counts every event that has the FCS/alignment error flag set.
- R9: Index 18 is 16 bits wide. It counts each event that has an FCS error, a runt length or an oversize length, and counts it once.
- R10: A read presented with `rd_en` at a clock edge returns, one cycle later with `rd_valid` high, the counter value from before that edge's update. An index of 19 or more returns 0. `rd_valid` is low in a cycle that follows no read.
- R11: With `cfg_rd_clear` high a read zeroes the counter it returns. If an event hits the same counter in the same cycle, the counter ends at that event's increment. With `cfg_rd_clear` low a read leaves the counter unchanged.
- R12: Counters saturate at all ones and never wrap.
- R13: An event changes only the counters of its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Packet-done event strobe |
| ev_port | input | PORT_W | Port of the event |
| ev_len | input | LEN_W | Packet length in bytes including CRC |
| ev_mcast | input | 1 | Multicast destination |
| ev_bcast | input | 1 | Broadcast destination |
| ev_fcs_err | input | 1 | FCS or alignment error |
| ev_drop | input | 1 | Packet marked for dropping |
| cfg_min_len | input | LEN_W | Minimum legal length |
| cfg_max_len | input | LEN_W | Maximum legal length |
| cfg_rd_clear | input | 1 | Reads clear the counter they return |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port to read |
| rd_idx | input | 5 | Counter index to read |
| rd_data | output | 64 | Counter value, zero-extended |
| rd_valid | output | 1 | rd_data holds a read result |

## Verification
A misclassified event shows up as a wrong value in exactly one counter, or as a missing one, the next time that counter is read. The read comes one cycle after the event at the earliest. A lost increment during a read-clear collision appears only on the read after the clearing read, so the bench reads the counter twice around a collision. A wrap instead of saturation appears only after 65 535 error events, so the 16-bit error counter is driven past its limit. Port isolation is checked by reading the idle ports after traffic on another port.

// File: rtl/rxstat_pkg.sv
`timescale 1ns/1ps
package rxstat_pkg;
  localparam int NCNT  = 19;
  localparam int IDX_W = 5;

  localparam int CI_PKTS     = 0;
  localparam int CI_OCTS     = 1;
  localparam int CI_DRP_PKTS = 2;
  localparam int CI_DRP_OCTS = 3;
  localparam int CI_MCAST    = 4;
  localparam int CI_BCAST    = 5;
  localparam int CI_BIN0     = 6;
  localparam int NBINS       = 7;
  localparam int CI_FCS      = 13;
  localparam int CI_RUNT     = 14;
  localparam int CI_RUNT_CRC = 15;
  localparam int CI_OVER     = 16;
  localparam int CI_OVER_CRC = 17;
  localparam int CI_ERRS     = 18;

  function automatic int cnt_width(int idx, int pkt_w, int oct_w, int err_w);
    if (idx == CI_OCTS) return oct_w;
    if (idx == CI_ERRS) return err_w;
    return pkt_w;
  endfunction

  function automatic bit cnt_adds_len(int idx);
    return (idx == CI_OCTS) || (idx == CI_DRP_OCTS);
  endfunction
endpackage

// File: rtl/rxstat_classify.sv
`timescale 1ns/1ps
module rxstat_classify
  import rxstat_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             valid,
  input  logic [LEN_W-1:0] len,
  input  logic             mcast,
  input  logic             bcast,
  input  logic             fcs_err,
  input  logic             drop,
  input  logic [LEN_W-1:0] min_len,
  input  logic [LEN_W-1:0] max_len,
  output logic [NCNT-1:0]  inc
);
  localparam logic [LEN_W-1:0] B64   = LEN_W'(64);
  localparam logic [LEN_W-1:0] B127  = LEN_W'(127);
  localparam logic [LEN_W-1:0] B255  = LEN_W'(255);
  localparam logic [LEN_W-1:0] B511  = LEN_W'(511);
  localparam logic [LEN_W-1:0] B1023 = LEN_W'(1023);
  localparam logic [LEN_W-1:0] B1518 = LEN_W'(1518);

  logic is_runt, is_over;

  always_comb begin
    is_runt = len < min_len;
    is_over = len > max_len;
    inc     = '0;
    if (valid) begin
      inc[CI_PKTS] = 1'b1;
      inc[CI_OCTS] = 1'b1;
      if (drop) begin
        inc[CI_DRP_PKTS] = 1'b1;
        inc[CI_DRP_OCTS] = 1'b1;
      end
      if (bcast)      inc[CI_BCAST] = 1'b1;
      else if (mcast) inc[CI_MCAST] = 1'b1;
      if (is_runt) begin
        if (fcs_err) inc[CI_RUNT_CRC] = 1'b1;
        else         inc[CI_RUNT]     = 1'b1;
      end
      if (is_over) begin
        if (fcs_err) inc[CI_OVER_CRC] = 1'b1;
        else         inc[CI_OVER]     = 1'b1;
      end
      if (fcs_err) inc[CI_FCS] = 1'b1;
      if (fcs_err || is_runt || is_over) inc[CI_ERRS] = 1'b1;
      if (!is_over && len >= B64) begin
        if (len == B64)        inc[CI_BIN0]     = 1'b1;
        else if (len <= B127)  inc[CI_BIN0 + 1] = 1'b1;
        else if (len <= B255)  inc[CI_BIN0 + 2] = 1'b1;
        else if (len <= B511)  inc[CI_BIN0 + 3] = 1'b1;
        else if (len <= B1023) inc[CI_BIN0 + 4] = 1'b1;
        else if (len <= B1518) inc[CI_BIN0 + 5] = 1'b1;
        else                   inc[CI_BIN0 + 6] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxstat_counter.sv
`timescale 1ns/1ps
module rxstat_counter #(
  parameter int W     = 32,
  parameter int AMT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [AMT_W-1:0] amt,
  input  logic             clr,
  output logic [W-1:0]     cnt
);
  localparam int PAD = W + 1 - AMT_W;

  logic [W:0]   amt_ext;
  logic [W:0]   sum;
  logic [W-1:0] nxt;
  logic         en;

  always_comb begin
    amt_ext = {{PAD{1'b0}}, amt};
    sum     = {1'b0, cnt} + amt_ext;
    en      = inc | clr;
    if (clr)      nxt = inc ? amt_ext[W-1:0] : '0;
    else if (sum[W]) nxt = '1;
    else          nxt = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= nxt;
  end
endmodule

// File: rtl/rxstat_readsel.sv
`timescale 1ns/1ps
module rxstat_readsel
  import rxstat_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int PORT_W = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rd_en,
  input  logic [PORT_W-1:0]                    rd_port,
  input  logic [IDX_W-1:0]                     rd_idx,
  input  logic [NPORTS-1:0][NCNT-1:0][63:0]    cnt_val,
  output logic [63:0]                          rd_data,
  output logic                                 rd_valid
);
  logic [63:0] sel;

  always_comb begin
    sel = '0;
    for (int p = 0; p < NPORTS; p++) begin
      for (int c = 0; c < NCNT; c++) begin
        if (rd_port == PORT_W'(p) && rd_idx == IDX_W'(c)) sel = cnt_val[p][c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/rxstat_bank.sv
`timescale 1ns/1ps
module rxstat_bank
  import rxstat_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int LEN_W  = 16,
  parameter int PKT_W  = 32,
  parameter int OCT_W  = 64,
  parameter int ERR_W  = 16,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_mcast,
  input  logic              ev_bcast,
  input  logic              ev_fcs_err,
  input  logic              ev_drop,
  input  logic [LEN_W-1:0]  cfg_min_len,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              cfg_rd_clear,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [4:0]        rd_idx,
  output logic [63:0]       rd_data,
  output logic              rd_valid
);
  logic [NCNT-1:0]                      ev_inc;
  logic [NPORTS-1:0][NCNT-1:0]          inc_all;
  logic [NPORTS-1:0][NCNT-1:0]          clr_all;
  logic [NPORTS-1:0][NCNT-1:0][63:0]    cnt_val;

  rxstat_classify #(.LEN_W(LEN_W)) u_classify (
    .valid   (ev_valid),
    .len     (ev_len),
    .mcast   (ev_mcast),
    .bcast   (ev_bcast),
    .fcs_err (ev_fcs_err),
    .drop    (ev_drop),
    .min_len (cfg_min_len),
    .max_len (cfg_max_len),
    .inc     (ev_inc)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      localparam int CW = cnt_width(c, PKT_W, OCT_W, ERR_W);
      logic [CW-1:0] q;

      assign inc_all[p][c] = ev_inc[c] & (ev_port == PORT_W'(p));
      assign clr_all[p][c] = rd_en & cfg_rd_clear &
                             (rd_port == PORT_W'(p)) & (rd_idx == IDX_W'(c));

      if (cnt_adds_len(c)) begin : g_oct
        rxstat_counter #(.W(CW), .AMT_W(LEN_W)) u_ctr (
          .clk (clk), .rst_n (rst_n), .inc (inc_all[p][c]),
          .amt (ev_len), .clr (clr_all[p][c]), .cnt (q)
        );
      end else begin : g_pkt
        rxstat_counter #(.W(CW), .AMT_W(1)) u_ctr (
          .clk (clk), .rst_n (rst_n), .inc (inc_all[p][c]),
          .amt (1'b1), .clr (clr_all[p][c]), .cnt (q)
        );
      end

      assign cnt_val[p][c] = 64'(q);
    end
  end

  rxstat_readsel #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_readsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_port  (rd_port),
    .rd_idx   (rd_idx),
    .cnt_val  (cnt_val),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/rxstat_bank_chk.sv
`timescale 1ns/1ps
module rxstat_bank_chk
  import rxstat_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              rd_en,
  input logic                              rd_valid,
  input logic [NCNT-1:0]                   ev_inc,
  input logic [NPORTS-1:0][NCNT-1:0]       inc_all,
  input logic [NPORTS-1:0][NCNT-1:0]       clr_all,
  input logic [NPORTS-1:0][NCNT-1:0][63:0] cnt_val
);
  assert_rdvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rdidle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_cast_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_inc[CI_MCAST], ev_inc[CI_BCAST]}));
  assert_one_bin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_inc[CI_BIN0 + NBINS - 1 : CI_BIN0]));
  assert_runt_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_inc[CI_RUNT], ev_inc[CI_RUNT_CRC]}));
  assert_over_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_inc[CI_OVER], ev_inc[CI_OVER_CRC]}));

  for (genvar p = 0; p < NPORTS; p++) begin : g_p
    for (genvar c = 0; c < NCNT; c++) begin : g_c
      assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all[p][c] && !inc_all[p][c]) |=> (cnt_val[p][c] == 64'd0));
      assert_no_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all[p][c] |=> (cnt_val[p][c] >= $past(cnt_val[p][c])));
    end
  end
endmodule

bind rxstat_bank rxstat_bank_chk #(.NPORTS(NPORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .ev_inc   (ev_inc),
  .inc_all  (inc_all),
  .clr_all  (clr_all),
  .cnt_val  (cnt_val)
);

// File: tb/rxstat_bank_bench.sv
`timescale 1ns/1ps
module rxstat_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, ev_mcast, ev_bcast, ev_fcs_err, ev_drop;
  logic [1:0]  ev_port, rd_port;
  logic [15:0] ev_len, cfg_min_len, cfg_max_len;
  logic        cfg_rd_clear, rd_en;
  logic [4:0]  rd_idx;
  logic [63:0] rd_data;
  logic        rd_valid;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rxstat_bank u_rxstat_bank (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_port(ev_port),
    .ev_len(ev_len), .ev_mcast(ev_mcast), .ev_bcast(ev_bcast),
    .ev_fcs_err(ev_fcs_err), .ev_drop(ev_drop), .cfg_min_len(cfg_min_len),
    .cfg_max_len(cfg_max_len), .cfg_rd_clear(cfg_rd_clear), .rd_en(rd_en),
    .rd_port(rd_port), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [15:0] mn, logic [15:0] mx);
    rst_n = 1'b0; ev_valid = 0; ev_port = 0; ev_len = 0; ev_mcast = 0;
    ev_bcast = 0; ev_fcs_err = 0; ev_drop = 0; cfg_rd_clear = 0;
    rd_en = 0; rd_port = 0; rd_idx = 0;
    cfg_min_len = mn; cfg_max_len = mx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive_ev(int p, int len, bit m, bit b, bit f, bit d);
    ev_valid = 1; ev_port = 2'(p); ev_len = 16'(len);
    ev_mcast = m; ev_bcast = b; ev_fcs_err = f; ev_drop = d;
  endtask

  task automatic send(int p, int len, bit m, bit b, bit f, bit d);
    drive_ev(p, len, m, b, f, d);
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic rd(int p, int idx, output logic [63:0] v);
    rd_en = 1; rd_port = 2'(p); rd_idx = 5'(idx);
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic expect_ctr(string req, int p, int idx, logic [63:0] exp);
    logic [63:0] v;
    rd(p, idx, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    do_reset(64, 1518);
    chk("R1 rd_valid", 64'(rd_valid), 0);
    chk("R1 rd_data", rd_data, 0);
    for (int c = 0; c < 19; c++) expect_ctr("R1 port0", 0, c, 0);
    for (int c = 0; c < 19; c++) expect_ctr("R1 port3", 3, c, 0);
  endtask

  task automatic t_totals();
    do_reset(64, 1518);
    send(1, 64, 0, 0, 0, 0);
    send(1, 100, 0, 0, 0, 0);
    send(1, 1518, 0, 0, 0, 0);
    expect_ctr("R2 pkts", 1, 0, 3);
    expect_ctr("R2 octets", 1, 1, 1682);
    expect_ctr("R13 port2 pkts", 2, 0, 0);
    expect_ctr("R13 port0 octets", 0, 1, 0);
  endtask

  task automatic t_drop();
    do_reset(64, 1518);
    send(2, 200, 0, 0, 0, 1);
    send(2, 300, 0, 0, 0, 1);
    send(2, 400, 0, 0, 0, 0);
    expect_ctr("R3 drop pkts", 2, 2, 2);
    expect_ctr("R3 drop octets", 2, 3, 500);
    expect_ctr("R2 pkts incl drops", 2, 0, 3);
  endtask

  task automatic t_cast();
    do_reset(64, 1518);
    send(0, 100, 1, 0, 0, 0);
    send(0, 100, 0, 1, 0, 0);
    send(0, 100, 1, 1, 0, 0);
    send(0, 100, 0, 0, 0, 0);
    expect_ctr("R4 mcast", 0, 4, 1);
    expect_ctr("R4 bcast", 0, 5, 2);
  endtask

  task automatic t_bins();
    int lens[15] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023,
                     1024, 1518, 1519, 2000, 2001};
    int exp_bin[7] = '{1, 2, 2, 2, 2, 2, 2};
    do_reset(64, 2000);
    foreach (lens[i]) send(3, lens[i], 0, 0, 0, 0);
    for (int b = 0; b < 7; b++) expect_ctr("R5 bin", 3, 6 + b, 64'(exp_bin[b]));
    expect_ctr("R6 runt from 63", 3, 14, 1);
    expect_ctr("R7 over from 2001", 3, 16, 1);
  endtask

  task automatic t_len_err();
    do_reset(64, 1518);
    send(1, 40, 0, 0, 0, 0);
    send(1, 50, 0, 0, 1, 0);
    send(1, 60, 0, 0, 1, 0);
    send(1, 1600, 0, 0, 0, 0);
    send(1, 1700, 0, 0, 1, 0);
    send(1, 100, 0, 0, 1, 0);
    send(1, 100, 0, 0, 0, 0);
    expect_ctr("R6 runt good", 1, 14, 1);
    expect_ctr("R6 runt crc", 1, 15, 2);
    expect_ctr("R7 over good", 1, 16, 1);
    expect_ctr("R7 over crc", 1, 17, 1);
    expect_ctr("R8 fcs", 1, 13, 4);
    expect_ctr("R9 errors", 1, 18, 6);
    expect_ctr("R5 no bin for runt", 1, 6, 0);
  endtask

  task automatic t_read();
    logic [63:0] v;
    do_reset(64, 1518);
    send(0, 80, 0, 0, 0, 0);
    send(0, 90, 0, 0, 0, 0);
    rd(0, 0, v);
    chk("R10 rd_valid high", 64'(rd_valid), 1);
    chk("R10 data", v, 2);
    @(negedge clk);
    chk("R10 rd_valid low", 64'(rd_valid), 0);
    expect_ctr("R11 no clear", 0, 0, 2);
    expect_ctr("R10 index 20", 0, 20, 0);
    drive_ev(0, 70, 0, 0, 0, 0);
    rd(0, 0, v);
    ev_valid = 0;
    chk("R10 pre-update value", v, 2);
    expect_ctr("R10 after update", 0, 0, 3);
  endtask

  task automatic t_rdclear();
    logic [63:0] v;
    do_reset(64, 1518);
    cfg_rd_clear = 1;
    send(0, 30, 0, 0, 0, 0);
    send(0, 30, 0, 0, 0, 0);
    send(0, 30, 0, 0, 0, 0);
    expect_ctr("R11 first read", 0, 0, 3);
    expect_ctr("R11 cleared", 0, 0, 0);
    expect_ctr("R11 octets", 0, 1, 90);
    send(0, 10, 0, 0, 0, 0);
    send(0, 10, 0, 0, 0, 0);
    drive_ev(0, 77, 0, 0, 0, 0);
    rd(0, 1, v);
    ev_valid = 0;
    chk("R11 collision read", v, 20);
    expect_ctr("R11 collision keeps event", 0, 1, 77);
    expect_ctr("R11 other counter kept", 0, 0, 3);
  endtask

  task automatic t_sat();
    do_reset(64, 1518);
    drive_ev(1, 100, 0, 0, 1, 0);
    repeat (65540) @(negedge clk);
    ev_valid = 0;
    expect_ctr("R12 error saturates", 1, 18, 65535);
    expect_ctr("R12 wide fcs count", 1, 13, 65540);
  endtask

  initial begin
    rst_n = 1'b0; ev_valid = 0; rd_en = 0; cfg_rd_clear = 0;
    ev_port = 0; ev_len = 0; ev_mcast = 0; ev_bcast = 0; ev_fcs_err = 0;
    ev_drop = 0; rd_port = 0; rd_idx = 0; cfg_min_len = 64; cfg_max_len = 1518;
    t_reset();
    t_totals();
    t_drop();
    t_cast();
    t_bins();
    t_len_err();
    t_read();
    t_rdclear();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule